// File: doc/BRIEF.md
# Per-Cycle Reconfigurable Multi-Hop Mesh Interconnect

This block is the operand-delivery fabric of a 4x4 array of processing elements. Each element owns one routing switch with four neighbour ports (north, east, south, west) and a local side that supplies two operand registers, A and B. Every switch reads one configuration word per cycle from its own 16-entry program store. The store is addressed by a program counter shared by all switches, so the crossbar of every switch can take a new setting on every clock.

Switches pass data through without latching it. A result value can therefore cross several switches and reach elements far from its source within one cycle. It can also be copied at any switch toward more than one destination. Only the operand registers at the end of a path, and a one-cycle copy of each element's own result, are clocked.

The program stores are loaded through a single write port while execution is halted. A synchronous reset sets every entry to the idle setting and clears all operands.

Top module: `hop_mesh`

## Requirements
- R1: After reset every operand output is zero. With no configuration written, the outputs stay zero whatever the result inputs carry, whether halted or running.
- R2: The configuration word of a switch is 18 bits. It holds six 3-bit select fields: north out [2:0], east out [5:3], south out [8:6], west out [11:9], operand A [14:12], operand B [17:15]. The select codes are 0 = north in, 1 = east in, 2 = south in, 3 = west in, 4 = this element's current result, 5 = this element's held result, and 6 or 7 = idle (drives zero).
- R3: A value routed during a cycle appears on the operand output after the next rising clock edge. Operand outputs are registered.
- R4: Code 5 supplies the element's result as it stood one cycle earlier, meaning the value sampled at the previous clock edge.
- R5: A value crosses any number of switches in the same cycle. For example, element 0 reaches element 3 through switches 1 and 2, and the result shows on operand A of element 3 one edge later.
- R6: One source reaches several destinations in the same cycle, including both operands of a single element, when switches copy it onto more than one output.
- R7: While `run` is high, the program counter advances by one on each edge and returns to 0 on the edge after it equals `loop_last`. The entry at the current count sets the routing for that cycle.
- R8: While `run` is low, the program counter is held at 0, so entry 0 sets the routing.
- R9: A configuration write lands when `run` is low. A write issued while `run` is high has no effect.
- R10: Selecting an input on a side of the mesh that has no neighbour yields zero. Element index i = row*4 + col, with row 0 at the north edge and col 0 at the west edge.
- R11: No cycle may have both ends of a link selecting each other's incoming value on that link. This configuration is illegal and is flagged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| run | input | 1 | High: program counter steps; low: halted at entry 0, writes allowed |
| loop_last | input | 4 | Last program entry before the counter wraps to 0 |
| cfg_we | input | 1 | Configuration write enable |
| cfg_sw | input | 4 | Switch (element) index to write |
| cfg_addr | input | 4 | Program entry to write |
| cfg_data | input | 18 | Configuration word, laid out as in R2 |
| res_in | input | 256 | Element results; element i in bits [16*i+15:16*i] |
| opnd_a | output | 256 | Registered operand A per element, same packing |
| opnd_b | output | 256 | Registered operand B per element, same packing |

## Verification
The bench drives every input on the falling edge. Routed values (R3, R5, R6, R10) are due on the operand outputs one rising edge after the cycle in which the routing is active, so the bench checks on the falling edge that follows that rising edge. A held result (R4) trails the current result by one more edge. With `run` raised just before edge k, the outputs after edge k+j show entry j modulo (`loop_last`+1) (R7), and the entry in each check is counted from that rule. A configuration write takes one edge to land and one more edge to reach the operands, so a check for a write that was accepted or ignored (R9) waits two edges after the write is issued.

// File: rtl/hopmesh_pkg.sv
package hopmesh_pkg;
  // select field geometry
  localparam int SELW    = 3;
  localparam int NFIELD  = 6;
  localparam int CFGW    = SELW * NFIELD;

  // field positions inside a configuration word (neighbour-visible order)
  localparam int FLD_N = 0;
  localparam int FLD_E = 1;
  localparam int FLD_S = 2;
  localparam int FLD_W = 3;
  localparam int FLD_A = 4;
  localparam int FLD_B = 5;

  // select codes
  localparam logic [SELW-1:0] SEL_NIN  = 3'd0;
  localparam logic [SELW-1:0] SEL_EIN  = 3'd1;
  localparam logic [SELW-1:0] SEL_SIN  = 3'd2;
  localparam logic [SELW-1:0] SEL_WIN  = 3'd3;
  localparam logic [SELW-1:0] SEL_RES  = 3'd4;
  localparam logic [SELW-1:0] SEL_HELD = 3'd5;
  localparam logic [SELW-1:0] SEL_OFF6 = 3'd6;
  localparam logic [SELW-1:0] SEL_IDLE = 3'd7;

  // all fields idle
  localparam logic [CFGW-1:0] CFG_IDLE = {NFIELD{SEL_IDLE}};

  function automatic logic [SELW-1:0] fld(input logic [CFGW-1:0] w, input int f);
    return w[f*SELW +: SELW];
  endfunction
endpackage

// File: rtl/hop_pc_seq.sv
module hop_pc_seq #(
  parameter int AW = 4
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          run,
  input  logic [AW-1:0] last,
  output logic [AW-1:0] pc
);
  always_ff @(posedge clk) begin
    if (rst || !run) begin
      pc <= '0;
    end else if (pc == last) begin
      pc <= '0;
    end else begin
      pc <= pc + 1'b1;
    end
  end

  AST_PC_HALT: assert property (@(posedge clk) disable iff (rst)
    !run |=> pc == '0); // R8
  AST_PC_WRAP: assert property (@(posedge clk) disable iff (rst)
    (pc == last) |=> pc == '0); // R7
  AST_PC_STEP: assert property (@(posedge clk) disable iff (rst)
    (run && pc != last) |=> pc == AW'($past(pc) + 1'b1)); // R7
endmodule

// File: rtl/hop_cfg_mem.sv
module hop_cfg_mem
  import hopmesh_pkg::*;
#(
  parameter int DEPTH = 16,
  localparam int AW = $clog2(DEPTH)
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            we,
  input  logic [AW-1:0]   waddr,
  input  logic [CFGW-1:0] wdata,
  input  logic [AW-1:0]   raddr,
  output logic [CFGW-1:0] rdata
);
  logic [CFGW-1:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int k = 0; k < DEPTH; k++) mem[k] <= CFG_IDLE;
    end else if (we) begin
      mem[waddr] <= wdata;
    end
  end

  // asynchronous read: the entry for this cycle must route in this cycle
  assign rdata = mem[raddr];

  AST_CLEAR_IDLE: assert property (@(posedge clk) disable iff (rst)
    $past(rst) |-> rdata == CFG_IDLE); // R1
  AST_WRITE_LANDS: assert property (@(posedge clk) disable iff (rst)
    we |=> mem[$past(waddr)] == $past(wdata)); // R9
endmodule

// File: rtl/hop_switch.sv
module hop_switch
  import hopmesh_pkg::*;
#(
  parameter int DW = 16
) (
  input  logic            clk,
  input  logic            rst,
  input  logic [CFGW-1:0] cfg,
  input  logic [DW-1:0]   res,
  input  logic [DW-1:0]   n_in,
  input  logic [DW-1:0]   e_in,
  input  logic [DW-1:0]   s_in,
  input  logic [DW-1:0]   w_in,
  output logic [DW-1:0]   n_out,
  output logic [DW-1:0]   e_out,
  output logic [DW-1:0]   s_out,
  output logic [DW-1:0]   w_out,
  output logic [DW-1:0]   opnd_a,
  output logic [DW-1:0]   opnd_b
);
  localparam int NSRC = 1 << SELW;

  logic [DW-1:0] res_q;
  logic [DW-1:0] src [NSRC];
  logic [DW-1:0] xo  [NFIELD];

  // source table indexed by select code
  always_comb begin
    for (int k = 0; k < NSRC; k++) src[k] = '0;
    src[SEL_NIN]  = n_in;
    src[SEL_EIN]  = e_in;
    src[SEL_SIN]  = s_in;
    src[SEL_WIN]  = w_in;
    src[SEL_RES]  = res;
    src[SEL_HELD] = res_q;
  end

  // one multiplexer per output field, no storage on the path
  for (genvar f = 0; f < NFIELD; f++) begin : g_xbar
    assign xo[f] = src[cfg[f*SELW +: SELW]];
  end

  assign n_out = xo[FLD_N];
  assign e_out = xo[FLD_E];
  assign s_out = xo[FLD_S];
  assign w_out = xo[FLD_W];

  always_ff @(posedge clk) begin
    if (rst) begin
      res_q  <= '0;
      opnd_a <= '0;
      opnd_b <= '0;
    end else begin
      res_q  <= res;
      opnd_a <= xo[FLD_A];
      opnd_b <= xo[FLD_B];
    end
  end

  AST_IDLE_ZERO_A: assert property (@(posedge clk) disable iff (rst)
    (fld(cfg, FLD_A) == SEL_IDLE || fld(cfg, FLD_A) == SEL_OFF6) |=> opnd_a == '0); // R2
  AST_LOCAL_A: assert property (@(posedge clk) disable iff (rst)
    (fld(cfg, FLD_A) == SEL_RES) |=> opnd_a == $past(res)); // R3
  AST_HELD_B: assert property (@(posedge clk) disable iff (rst)
    (fld(cfg, FLD_B) == SEL_HELD && !$past(rst)) |=> opnd_b == $past(res, 2)); // R4
endmodule

// File: rtl/hop_mesh.sv
module hop_mesh
  import hopmesh_pkg::*;
#(
  parameter int ROWS  = 4,
  parameter int COLS  = 4,
  parameter int DW    = 16,
  parameter int DEPTH = 16,
  localparam int NSW  = ROWS * COLS,
  localparam int AW   = $clog2(DEPTH),
  localparam int SWW  = $clog2(NSW)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              run,
  input  logic [AW-1:0]     loop_last,
  input  logic              cfg_we,
  input  logic [SWW-1:0]    cfg_sw,
  input  logic [AW-1:0]     cfg_addr,
  input  logic [CFGW-1:0]   cfg_data,
  input  logic [NSW*DW-1:0] res_in,
  output logic [NSW*DW-1:0] opnd_a,
  output logic [NSW*DW-1:0] opnd_b
);
  logic [AW-1:0]   pc;
  logic [CFGW-1:0] cfg_word [NSW];
  logic [DW-1:0]   to_n [NSW];
  logic [DW-1:0]   to_e [NSW];
  logic [DW-1:0]   to_s [NSW];
  logic [DW-1:0]   to_w [NSW];
  logic [DW-1:0]   fr_n [NSW];
  logic [DW-1:0]   fr_e [NSW];
  logic [DW-1:0]   fr_s [NSW];
  logic [DW-1:0]   fr_w [NSW];

  hop_pc_seq #(.AW(AW)) i_pc (
    .clk (clk),
    .rst (rst),
    .run (run),
    .last(loop_last),
    .pc  (pc)
  );

  for (genvar r = 0; r < ROWS; r++) begin : g_row
    for (genvar c = 0; c < COLS; c++) begin : g_col
      localparam int I = r * COLS + c;

      // mesh edges read zero where there is no neighbour
      if (r > 0) begin : g_n
        assign fr_n[I] = to_s[I-COLS];
      end else begin : g_n0
        assign fr_n[I] = '0;
      end
      if (r < ROWS - 1) begin : g_s
        assign fr_s[I] = to_n[I+COLS];
      end else begin : g_s0
        assign fr_s[I] = '0;
      end
      if (c > 0) begin : g_w
        assign fr_w[I] = to_e[I-1];
      end else begin : g_w0
        assign fr_w[I] = '0;
      end
      if (c < COLS - 1) begin : g_e
        assign fr_e[I] = to_w[I+1];
      end else begin : g_e0
        assign fr_e[I] = '0;
      end

      hop_cfg_mem #(.DEPTH(DEPTH)) i_mem (
        .clk  (clk),
        .rst  (rst),
        .we   (cfg_we && !run && (cfg_sw == SWW'(I))),
        .waddr(cfg_addr),
        .wdata(cfg_data),
        .raddr(pc),
        .rdata(cfg_word[I])
      );

      hop_switch #(.DW(DW)) i_sw (
        .clk   (clk),
        .rst   (rst),
        .cfg   (cfg_word[I]),
        .res   (res_in[I*DW +: DW]),
        .n_in  (fr_n[I]),
        .e_in  (fr_e[I]),
        .s_in  (fr_s[I]),
        .w_in  (fr_w[I]),
        .n_out (to_n[I]),
        .e_out (to_e[I]),
        .s_out (to_s[I]),
        .w_out (to_w[I]),
        .opnd_a(opnd_a[I*DW +: DW]),
        .opnd_b(opnd_b[I*DW +: DW])
      );

      // a link whose two ends forward each other's value forms a loop
      if (c < COLS - 1) begin : g_chk_h
        AST_NO_PINGPONG_H: assert property (@(posedge clk) disable iff (rst)
          !(fld(cfg_word[I], FLD_E) == SEL_EIN &&
            fld(cfg_word[I+1], FLD_W) == SEL_WIN)); // R11
      end
      if (r < ROWS - 1) begin : g_chk_v
        AST_NO_PINGPONG_V: assert property (@(posedge clk) disable iff (rst)
          !(fld(cfg_word[I], FLD_S) == SEL_SIN &&
            fld(cfg_word[I+COLS], FLD_N) == SEL_NIN)); // R11
      end
    end
  end
endmodule

// File: tb/test_hop_mesh.sv
module test_hop_mesh;
  logic         clk = 1'b0;
  logic         rst;
  logic         run;
  logic [3:0]   loop_last;
  logic         cfg_we;
  logic [3:0]   cfg_sw;
  logic [3:0]   cfg_addr;
  logic [17:0]  cfg_data;
  logic [255:0] res_in;
  logic [255:0] opnd_a;
  logic [255:0] opnd_b;

  int total = 0;
  int bad   = 0;
  bit done  = 1'b0;

  localparam logic [2:0] X = 3'd7; // idle

  always #2 clk = ~clk;

  hop_mesh i_hop_mesh (
    .clk(clk), .rst(rst), .run(run), .loop_last(loop_last),
    .cfg_we(cfg_we), .cfg_sw(cfg_sw), .cfg_addr(cfg_addr), .cfg_data(cfg_data),
    .res_in(res_in), .opnd_a(opnd_a), .opnd_b(opnd_b)
  );

  function automatic logic [17:0] mk(logic [2:0] n, logic [2:0] e, logic [2:0] s,
                                     logic [2:0] w, logic [2:0] a, logic [2:0] b);
    return {b, a, w, s, e, n};
  endfunction

  function automatic logic [15:0] oa(int i);
    return opnd_a[i*16 +: 16];
  endfunction

  function automatic logic [15:0] ob(int i);
    return opnd_b[i*16 +: 16];
  endfunction

  task automatic chk(string req, logic [255:0] got, logic [255:0] exp);
    total++;
    if (got !== exp) begin
      bad++;
      $display("FAIL %s: got %h expected %h", req, got, exp);
    end
  endtask

  task automatic tick();
    @(negedge clk);
  endtask

  task automatic setres(int i, logic [15:0] v);
    res_in[i*16 +: 16] = v;
  endtask

  task automatic do_reset();
    rst = 1'b1; run = 1'b0; loop_last = '0; cfg_we = 1'b0;
    cfg_sw = '0; cfg_addr = '0; cfg_data = '0; res_in = '0;
    tick(); tick();
    rst = 1'b0;
  endtask

  task automatic wr(int sw, int addr, logic [17:0] d);
    cfg_we = 1'b1; cfg_sw = 4'(sw); cfg_addr = 4'(addr); cfg_data = d;
    tick();
    cfg_we = 1'b0;
  endtask

  // R1: reset state and idle configuration
  task automatic t_reset();
    do_reset();
    chk("R1 operands after reset", opnd_a | opnd_b, '0);
    for (int i = 0; i < 16; i++) setres(i, 16'(16'h1357 * (i + 1)));
    tick();
    chk("R1 halted idle", opnd_a | opnd_b, '0);
    loop_last = 4'd3; run = 1'b1;
    for (int k = 0; k < 5; k++) tick();
    chk("R1 running idle", opnd_a | opnd_b, '0);
  endtask

  // R3, R4: current and held local result
  task automatic t_local();
    do_reset();
    wr(5, 0, mk(X, X, X, X, 3'd4, 3'd5));
    setres(5, 16'h1111);
    tick();
    setres(5, 16'h2222);
    tick();
    chk("R3 current result on A", 256'(oa(5)), 256'(16'h2222));
    chk("R4 held result on B", 256'(ob(5)), 256'(16'h1111));
  endtask

  // R2: every direction field and input code, on the centre switch 5
  task automatic t_fields();
    do_reset();
    for (int i = 0; i < 16; i++) setres(i, 16'(16'h0101 * (i + 1)));
    wr(5, 0, mk(3'd4, 3'd4, 3'd4, 3'd4, X, X));
    wr(1, 0, mk(X, X, X, X, 3'd2, X)); // from south
    wr(6, 0, mk(X, X, X, X, 3'd3, X)); // from west
    wr(9, 0, mk(X, X, X, X, 3'd0, X)); // from north
    wr(4, 0, mk(X, X, X, X, X, 3'd1)); // from east, on B
    wr(7, 0, mk(X, X, X, X, 3'd6, 3'd4));
    tick();
    chk("R2 north field", 256'(oa(1)), 256'(16'h0606));
    chk("R2 east field", 256'(oa(6)), 256'(16'h0606));
    chk("R2 south field", 256'(oa(9)), 256'(16'h0606));
    chk("R2 west field to B", 256'(ob(4)), 256'(16'h0606));
    chk("R2 code 6 idle", 256'(oa(7)), 256'(16'h0000));
    chk("R2 B field local", 256'(ob(7)), 256'(16'h0808));
  endtask

  // R5, R6: multi-hop and fan-out in one cycle
  task automatic t_multihop();
    do_reset();
    for (int i = 0; i < 16; i++) setres(i, 16'(16'h1000 + i));
    setres(0, 16'hBEEF);
    wr(0, 0, mk(X, 3'd4, X, X, X, X));
    wr(1, 0, mk(X, 3'd3, X, X, X, X));
    wr(2, 0, mk(X, 3'd3, X, X, X, X));
    wr(3, 0, mk(X, X, 3'd3, X, 3'd3, X));
    wr(7, 0, mk(X, X, 3'd0, X, X, X));
    wr(11, 0, mk(X, X, 3'd0, X, X, X));
    wr(15, 0, mk(X, X, X, X, 3'd0, 3'd0));
    tick();
    chk("R5 three hops to element 3", 256'(oa(3)), 256'(16'hBEEF));
    chk("R5 six hops to element 15", 256'(oa(15)), 256'(16'hBEEF));
    chk("R6 fan-out to both operands", 256'(ob(15)), 256'(16'hBEEF));
    chk("R6 pass-through element keeps A idle", 256'(oa(1)), 256'(16'h0000));
  endtask

  // R10: inputs on the mesh edge read zero
  task automatic t_edge();
    do_reset();
    for (int i = 0; i < 16; i++) setres(i, 16'hFFFF);
    wr(0, 0, mk(X, X, X, X, 3'd0, 3'd3));
    wr(15, 0, mk(X, X, X, X, 3'd1, 3'd2));
    tick();
    chk("R10 north/west edge of element 0", opnd_a[15:0] | opnd_b[15:0], '0);
    chk("R10 east/south edge of element 15", 256'(oa(15) | ob(15)), '0);
  endtask

  // R7, R8: per-cycle program, wrap and halt
  task automatic t_program();
    do_reset();
    setres(4, 16'hAAAA);
    setres(5, 16'h5555);
    wr(5, 0, mk(X, X, X, X, 3'd4, X));
    wr(5, 1, mk(X, X, X, X, X, X));
    wr(5, 2, mk(X, X, X, X, 3'd3, X));
    wr(4, 2, mk(X, 3'd4, X, X, X, X));
    loop_last = 4'd2;
    tick();
    chk("R8 halted uses entry 0", 256'(oa(5)), 256'(16'h5555));
    run = 1'b1;
    tick(); chk("R7 step entry 0", 256'(oa(5)), 256'(16'h5555));
    tick(); chk("R7 step entry 1", 256'(oa(5)), 256'(16'h0000));
    tick(); chk("R7 step entry 2", 256'(oa(5)), 256'(16'hAAAA));
    tick(); chk("R7 wrap to entry 0", 256'(oa(5)), 256'(16'h5555));
    tick(); chk("R7 after wrap entry 1", 256'(oa(5)), 256'(16'h0000));
    run = 1'b0;
    tick(); chk("R7 last running entry 2", 256'(oa(5)), 256'(16'hAAAA));
    tick(); chk("R8 halt returns to entry 0", 256'(oa(5)), 256'(16'h5555));
    tick(); chk("R8 halt holds entry 0", 256'(oa(5)), 256'(16'h5555));
  endtask

  // R9: writes ignored while running, accepted while halted
  task automatic t_write_gate();
    do_reset();
    setres(6, 16'h6666);
    wr(6, 0, mk(X, X, X, X, 3'd4, X));
    loop_last = 4'd0;
    run = 1'b1;
    tick();
    wr(6, 0, mk(X, X, X, X, X, X));
    tick();
    chk("R9 write while running ignored", 256'(oa(6)), 256'(16'h6666));
    run = 1'b0;
    wr(6, 0, mk(X, X, X, X, X, X));
    tick();
    chk("R9 write while halted lands", 256'(oa(6)), 256'(16'h0000));
  endtask

  initial begin
    for (int k = 0; k < 100000; k++) @(posedge clk);
    if (!done) begin
      bad++; total++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    t_reset();
    t_local();
    t_fields();
    t_multihop();
    t_edge();
    t_program();
    t_write_gate();
    done = 1'b1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule